// File: doc/BRIEF.md
# Branch and Next-PC Unit

This block decides where a 32-bit word-aligned RISC core fetches next. Each cycle it takes the current instruction word, the program counter of that instruction, the stored N, Z, V, C condition flags and the sum of the two register operands (rs1 + rs2). It recognises three kinds of control transfer: a long-range call, a flag-conditional PC-relative branch, and a register-indirect jump that saves a return address. From these it produces the next PC and a link-register write request.

Alongside this it presents two operand immediates taken from the same word. One is the 13-bit signed immediate widened to 32 bits. The other is the set-high value, which places a 22-bit field in the upper bits of a register. Every output is registered, so results appear one clock after the inputs are sampled. Annulled branches and delay slots are not modelled: a taken transfer redirects the very next fetch.

Top module: `bnpc_unit`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is cleared to zero at that edge.
- R2: Outputs at each rising edge reflect the inputs sampled at that same edge, so they are visible one cycle after being driven. Outputs update every cycle with no stall.
- R3: A word with bits[31:30]=01 is a call. It sets next PC to PC + (bits[29:0] << 2), modulo 2^32, and raises the redirect output. It also requests a link write of the old PC to register 15.
- R4: A word with bits[31:30]=00 and bits[24:22]=010 is a conditional branch. Its condition code is bits[28:25] and its displacement is bits[21:0]. When taken, next PC is PC plus the displacement sign-extended and shifted left by two, and the redirect output is high. When not taken, next PC is PC + 4 and redirect is low. A branch never writes a link register, and bit 29 has no effect.
- R5: With flags input bits {3:N, 2:Z, 1:V, 0:C}, condition codes 1 to 7 are taken when the following hold. Code 1: Z. Code 2: Z or (N xor V). Code 3: N xor V. Code 4: C or Z. Code 5: C. Code 6: N. Code 7: V.
- R6: Code 0 is never taken and code 8 is always taken. Codes 9 to 15 are the logical complements of codes 1 to 7, so code 9 is taken exactly when Z is 0.
- R7: A word with bits[31:30]=10 and bits[24:19]=111000 is a jump-and-link. Next PC is the rs1+rs2 sum input and redirect is high. The old PC is written to the register named by bits[29:25].
- R8: A link write aimed at register 0 is discarded: the write enable stays low and the redirect still takes place. Whenever no link write is requested, the link index and link value outputs are zero.
- R9: Any word that is none of the three control transfers gives next PC = PC + 4, with redirect and link write low. This includes the set-high format (bits[31:30]=00, bits[24:22]=100).
- R10: The signed-immediate output is bits[12:0] sign-extended to 32 bits, for every word.
- R11: The set-high output is bits[21:0] placed in bits 31:10, with bits 9:0 zero, for every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| i_inst | input | 32 | Instruction word |
| i_pc | input | 32 | Address of the instruction |
| i_flags | input | 4 | Stored flags {N, Z, V, C} |
| i_rs_sum | input | 32 | rs1 + rs2 sum for the indirect jump |
| o_next_pc | output | 32 | Next fetch address |
| o_redirect | output | 1 | High when a control transfer is taken |
| o_link_we | output | 1 | Link register write enable |
| o_link_idx | output | 5 | Link register index |
| o_link_val | output | 32 | Link value (old PC) |
| o_simm32 | output | 32 | Sign-extended 13-bit immediate |
| o_sethi32 | output | 32 | Set-high immediate value |

## Verification
The redirect and the link write come from separate decode paths, yet they must agree in the same cycle. A call or jump-and-link must raise both together, while a branch or a jump-and-link with destination 0 must redirect with the write suppressed. The bench provokes this by sweeping the jump-and-link destination over all 32 registers and by running calls and branches back to back. Each cycle it judges next PC, redirect, enable, index and value together against one arithmetic model. Every branch condition is also swept against all sixteen flag combinations with the annul bit toggled.

// File: rtl/bnpc_pkg.sv
// Package: shared constants and types for the branch and next-PC unit.
// Assumes 32-bit instruction words and word-aligned program counters.
package bnpc_pkg;
    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int COND_W    = 4;
    localparam int FLAG_W    = 4;

    localparam logic [1:0] OP_CALL   = 2'b01;
    localparam logic [1:0] OP_FMT2   = 2'b00;
    localparam logic [1:0] OP_ARITH  = 2'b10;
    localparam logic [2:0] SUB_BRCH  = 3'b010;
    localparam logic [2:0] SUB_SETHI = 3'b100;
    localparam logic [5:0] FN_JLINK  = 6'b111000;

    // Flag positions inside the flags vector.
    localparam int FLG_N = 3;
    localparam int FLG_Z = 2;
    localparam int FLG_V = 1;
    localparam int FLG_C = 0;

    typedef enum logic [1:0] {
        XFER_NONE   = 2'd0,
        XFER_CALL   = 2'd1,
        XFER_BRANCH = 2'd2,
        XFER_JLINK  = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e             kind;
        logic [COND_W-1:0]      cond;
        logic [REG_IDX_W-1:0]   rd;
    } xfer_dec_t;
endpackage

// File: rtl/bnpc_decode.sv
// Module: bnpc_decode
// Classifies an instruction word into one of the control-transfer kinds and
// extracts the branch condition and destination register fields.
// Assumes a single 32-bit word; purely combinational.
module bnpc_decode
    import bnpc_pkg::*;
(
    input  logic [XLEN-1:0] i_inst,
    output xfer_dec_t       o_dec
);
    logic [1:0] op_top;
    logic [2:0] op_sub;
    logic [5:0] op_fn;
    logic       unused_ok;

    assign op_top    = i_inst[31:30];
    assign op_sub    = i_inst[24:22];
    assign op_fn     = i_inst[24:19];
    // Source register and mode bits are consumed elsewhere in the core.
    assign unused_ok = ^i_inst[18:13];

    // Pick the transfer kind from the format and function fields.
    always_comb begin
        o_dec.kind = XFER_NONE;
        o_dec.cond = i_inst[28:25];
        o_dec.rd   = i_inst[29:25];
        unique case (op_top)
            OP_CALL:  o_dec.kind = XFER_CALL;
            OP_FMT2:  if (op_sub == SUB_BRCH) o_dec.kind = XFER_BRANCH;
            OP_ARITH: if (op_fn == FN_JLINK)  o_dec.kind = XFER_JLINK;
            default:  o_dec.kind = XFER_NONE;
        endcase
    end
endmodule

// File: rtl/bnpc_cond.sv
// Module: bnpc_cond
// Evaluates a 4-bit branch condition against the stored flags. The low
// three code bits select a base test; the top bit inverts it.
// Assumes flags ordered {N, Z, V, C}; purely combinational.
module bnpc_cond
    import bnpc_pkg::*;
(
    input  logic [COND_W-1:0] i_cond,
    input  logic [FLAG_W-1:0] i_flags,
    output logic              o_taken
);
    localparam int N_BASE = 1 << (COND_W - 1);

    logic              fn, fz, fv, fc;
    logic [N_BASE-1:0] base_test;

    assign fn = i_flags[FLG_N];
    assign fz = i_flags[FLG_Z];
    assign fv = i_flags[FLG_V];
    assign fc = i_flags[FLG_C];

    // Build the eight base tests, one per low-code value.
    genvar gi;
    generate
        for (gi = 0; gi < N_BASE; gi++) begin : g_base
            if (gi == 0)      begin : g_never assign base_test[gi] = 1'b0;            end
            else if (gi == 1) begin : g_eq    assign base_test[gi] = fz;              end
            else if (gi == 2) begin : g_le    assign base_test[gi] = fz | (fn ^ fv);  end
            else if (gi == 3) begin : g_lt    assign base_test[gi] = fn ^ fv;         end
            else if (gi == 4) begin : g_leu   assign base_test[gi] = fc | fz;         end
            else if (gi == 5) begin : g_cs    assign base_test[gi] = fc;              end
            else if (gi == 6) begin : g_neg   assign base_test[gi] = fn;              end
            else              begin : g_vs    assign base_test[gi] = fv;              end
        end
    endgenerate

    // Select the base test and apply the inversion bit.
    always_comb begin
        o_taken = base_test[i_cond[COND_W-2:0]] ^ i_cond[COND_W-1];
    end
endmodule

// File: rtl/bnpc_imm.sv
// Module: bnpc_imm
// Forms the immediates and displacements carried in an instruction word:
// signed 13-bit operand, set-high value, call and branch byte offsets.
// Assumes 32-bit words; purely combinational.
module bnpc_imm
    import bnpc_pkg::*;
#(
    parameter int SIMM_W  = 13,
    parameter int HI_W    = 22,
    parameter int BDISP_W = 22
) (
    input  logic [XLEN-1:0] i_inst,
    output logic [XLEN-1:0] o_simm32,
    output logic [XLEN-1:0] o_sethi32,
    output logic [XLEN-1:0] o_call_off,
    output logic [XLEN-1:0] o_br_off
);
    localparam int CDISP_W = XLEN - 2;
    localparam int LO_W    = XLEN - HI_W;

    logic [SIMM_W-1:0]  simm_f;
    logic [BDISP_W-1:0] bdisp_f;

    assign simm_f  = i_inst[SIMM_W-1:0];
    assign bdisp_f = i_inst[BDISP_W-1:0];

    // Widen the signed operand immediate.
    always_comb o_simm32 = {{(XLEN-SIMM_W){simm_f[SIMM_W-1]}}, simm_f};

    // Place the set-high field on top and clear the low bits.
    always_comb o_sethi32 = {i_inst[HI_W-1:0], {LO_W{1'b0}}};

    // Word-align the call displacement; it spans the whole space.
    always_comb o_call_off = {i_inst[CDISP_W-1:0], 2'b00};

    // Sign-extend and word-align the branch displacement.
    always_comb o_br_off = {{(XLEN-BDISP_W-2){bdisp_f[BDISP_W-1]}}, bdisp_f, 2'b00};
endmodule

// File: rtl/bnpc_unit.sv
// Module: bnpc_unit (top)
// Computes the next fetch address and the link-register write for call,
// conditional branch and register-indirect jump-and-link; also presents the
// operand immediates. All outputs are registered (one-cycle latency).
// Assumes word-aligned PC; synchronous active-low reset clears all outputs.
module bnpc_unit
    import bnpc_pkg::*;
#(
    parameter int LINK_REG = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [XLEN-1:0]      i_inst,
    input  logic [XLEN-1:0]      i_pc,
    input  logic [FLAG_W-1:0]    i_flags,
    input  logic [XLEN-1:0]      i_rs_sum,
    output logic [XLEN-1:0]      o_next_pc,
    output logic                 o_redirect,
    output logic                 o_link_we,
    output logic [REG_IDX_W-1:0] o_link_idx,
    output logic [XLEN-1:0]      o_link_val,
    output logic [XLEN-1:0]      o_simm32,
    output logic [XLEN-1:0]      o_sethi32
);
    localparam logic [REG_IDX_W-1:0] LINK_IDX = REG_IDX_W'(LINK_REG);
    localparam logic [XLEN-1:0]      STEP     = XLEN'(4);

    xfer_dec_t              dec;
    logic                   br_taken;
    logic [XLEN-1:0]        simm_c, sethi_c, call_off, br_off;
    logic [XLEN-1:0]        npc_c, lval_c;
    logic                   redir_c, lwe_c;
    logic [REG_IDX_W-1:0]   lidx_c, ltarget;

    bnpc_decode u_dec (
        .i_inst (i_inst),
        .o_dec  (dec)
    );

    bnpc_cond u_cond (
        .i_cond  (dec.cond),
        .i_flags (i_flags),
        .o_taken (br_taken)
    );

    bnpc_imm u_imm (
        .i_inst     (i_inst),
        .o_simm32   (simm_c),
        .o_sethi32  (sethi_c),
        .o_call_off (call_off),
        .o_br_off   (br_off)
    );

    // Choose next PC and redirect from the transfer kind.
    always_comb begin
        npc_c   = i_pc + STEP;
        redir_c = 1'b0;
        ltarget = '0;
        unique case (dec.kind)
            XFER_CALL: begin
                npc_c   = i_pc + call_off;
                redir_c = 1'b1;
                ltarget = LINK_IDX;
            end
            XFER_BRANCH: begin
                if (br_taken) begin
                    npc_c   = i_pc + br_off;
                    redir_c = 1'b1;
                end
            end
            XFER_JLINK: begin
                npc_c   = i_rs_sum;
                redir_c = 1'b1;
                ltarget = dec.rd;
            end
            default: ;
        endcase
    end

    // Form the link write; register 0 targets are dropped.
    always_comb begin
        lwe_c  = (ltarget != '0);
        lidx_c = lwe_c ? ltarget : '0;
        lval_c = lwe_c ? i_pc : '0;
    end

    // Register all results; reset clears them.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_next_pc  <= '0;
            o_redirect <= 1'b0;
            o_link_we  <= 1'b0;
            o_link_idx <= '0;
            o_link_val <= '0;
            o_simm32   <= '0;
            o_sethi32  <= '0;
        end else begin
            o_next_pc  <= npc_c;
            o_redirect <= redir_c;
            o_link_we  <= lwe_c;
            o_link_idx <= lidx_c;
            o_link_val <= lval_c;
            o_simm32   <= simm_c;
            o_sethi32  <= sethi_c;
        end
    end
endmodule

// File: rtl/bnpc_unit_chk.sv
// Module: bnpc_unit_chk
// Assertion checker bound to bnpc_unit; relates registered outputs to the
// inputs sampled one edge earlier.
module bnpc_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] i_inst,
    input logic [31:0] i_pc,
    input logic [31:0] i_rs_sum,
    input logic [31:0] o_next_pc,
    input logic        o_redirect,
    input logic        o_link_we,
    input logic [4:0]  o_link_idx,
    input logic [31:0] o_link_val,
    input logic [31:0] o_simm32,
    input logic [31:0] o_sethi32
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (o_next_pc == 32'd0 && !o_redirect && !o_link_we && o_link_val == 32'd0));

    assert_call_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(i_inst[31:30]) == 2'b01) |->
        (o_redirect && o_link_we && o_link_idx == 5'd15 && o_link_val == $past(i_pc)
         && o_next_pc == $past(i_pc) + {$past(i_inst[29:0]), 2'b00}));

    assert_never_branch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(i_inst[31:30]) == 2'b00 && $past(i_inst[24:22]) == 3'b010
         && $past(i_inst[28:25]) == 4'b0000) |->
        (!o_redirect && o_next_pc == $past(i_pc) + 32'd4));

    assert_jlink_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(i_inst[31:30]) == 2'b10 && $past(i_inst[24:19]) == 6'b111000) |->
        (o_redirect && o_next_pc == $past(i_rs_sum)));

    assert_no_r0_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        o_link_we |-> o_link_idx != 5'd0);

    assert_sequential_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !o_redirect) |-> (o_next_pc == $past(i_pc) + 32'd4 && !o_link_we));

    assert_simm_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> o_simm32 == {{19{$past(i_inst[12])}}, $past(i_inst[12:0])});

    assert_sethi_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> o_sethi32 == {$past(i_inst[21:0]), 10'd0});
endmodule

bind bnpc_unit bnpc_unit_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .i_inst     (i_inst),
    .i_pc       (i_pc),
    .i_rs_sum   (i_rs_sum),
    .o_next_pc  (o_next_pc),
    .o_redirect (o_redirect),
    .o_link_we  (o_link_we),
    .o_link_idx (o_link_idx),
    .o_link_val (o_link_val),
    .o_simm32   (o_simm32),
    .o_sethi32  (o_sethi32)
);

// File: tb/sim_bnpc_unit.sv
// Bench for bnpc_unit: sweeps conditions x flags, call and jump-and-link
// destinations, and non-transfer formats against an arithmetic model.
module sim_bnpc_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] i_inst = '0;
    logic [31:0] i_pc = '0;
    logic [3:0]  i_flags = '0;
    logic [31:0] i_rs_sum = '0;
    logic [31:0] o_next_pc, o_link_val, o_simm32, o_sethi32;
    logic        o_redirect, o_link_we;
    logic [4:0]  o_link_idx;

    int n_vec = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bnpc_unit u0 (
        .clk(clk), .rst_n(rst_n), .i_inst(i_inst), .i_pc(i_pc),
        .i_flags(i_flags), .i_rs_sum(i_rs_sum), .o_next_pc(o_next_pc),
        .o_redirect(o_redirect), .o_link_we(o_link_we), .o_link_idx(o_link_idx),
        .o_link_val(o_link_val), .o_simm32(o_simm32), .o_sethi32(o_sethi32)
    );

    // Condition truth per code, written out per code (R5, R6).
    function automatic logic cond_ok(input logic [3:0] c, input logic [3:0] f);
        logic n, z, v, cy;
        {n, z, v, cy} = f;
        case (c)
            4'd0:  return 1'b0;
            4'd1:  return z;
            4'd2:  return z || (n != v);
            4'd3:  return n != v;
            4'd4:  return cy || z;
            4'd5:  return cy;
            4'd6:  return n;
            4'd7:  return v;
            4'd8:  return 1'b1;
            4'd9:  return !z;
            4'd10: return !z && (n == v);
            4'd11: return n == v;
            4'd12: return !cy && !z;
            4'd13: return !cy;
            4'd14: return !n;
            default: return !v;
        endcase
    endfunction

    // Drive one vector, wait for its registered result, and compare.
    task automatic run(input logic [31:0] inst, input logic [31:0] pc,
                       input logic [3:0] fl, input logic [31:0] sum, input string tag);
        logic [31:0] e_npc, e_lval, e_simm, e_hi;
        logic        e_red, e_we;
        logic [4:0]  e_idx;
        @(negedge clk);
        i_inst = inst; i_pc = pc; i_flags = fl; i_rs_sum = sum;
        e_npc = pc + 32'd4; e_red = 0; e_we = 0; e_idx = 0; e_lval = 0;
        e_simm = 32'($signed(inst[12:0]));
        e_hi   = inst[21:0] * 32'd1024;
        if (inst[31:30] == 2'b01) begin
            e_npc = pc + inst[29:0] * 32'd4; e_red = 1; e_we = 1; e_idx = 15; e_lval = pc;
        end else if (inst[31:30] == 2'b00 && inst[24:22] == 3'b010) begin
            if (cond_ok(inst[28:25], fl)) begin
                e_npc = pc + 32'($signed(inst[21:0])) * 32'd4; e_red = 1;
            end
        end else if (inst[31:30] == 2'b10 && inst[24:19] == 6'b111000) begin
            e_npc = sum; e_red = 1;
            if (inst[29:25] != 0) begin e_we = 1; e_idx = inst[29:25]; e_lval = pc; end
        end
        @(negedge clk);
        n_vec++;
        if (o_next_pc !== e_npc || o_redirect !== e_red || o_link_we !== e_we ||
            o_link_idx !== e_idx || o_link_val !== e_lval || o_simm32 !== e_simm ||
            o_sethi32 !== e_hi) begin
            n_bad++;
            $display("FAIL %s inst=%h got npc=%h red=%b we=%b idx=%0d lv=%h simm=%h hi=%h exp npc=%h red=%b we=%b idx=%0d lv=%h simm=%h hi=%h",
                     tag, inst, o_next_pc, o_redirect, o_link_we, o_link_idx, o_link_val,
                     o_simm32, o_sethi32, e_npc, e_red, e_we, e_idx, e_lval, e_simm, e_hi);
        end
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        // R1: outputs under reset
        i_inst = 32'h7fff_ffff; i_pc = 32'h1234_5678;
        repeat (3) @(negedge clk);
        n_vec++;
        if (o_next_pc !== 0 || o_redirect !== 0 || o_link_we !== 0 || o_link_idx !== 0 ||
            o_link_val !== 0 || o_simm32 !== 0 || o_sethi32 !== 0) begin
            n_bad++;
            $display("FAIL R1 got npc=%h red=%b we=%b exp all zero", o_next_pc, o_redirect, o_link_we);
        end
        rst_n = 1'b1;

        // R4 R5 R6: every condition against every flag set, annul toggled
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 16; f++) begin
                logic [21:0] d;
                d = 22'((c * 16 + f) * 32'd98765 + 32'd7);
                if (f[0]) d[21] = 1'b1;
                run({2'b00, f[1], 4'(c), 3'b010, d}, 32'h0040_0000 + 32'(c * 64 + f * 4),
                    4'(f), 32'hdead_beec, "R5_R6_R4");
            end
        end
        // R4: displacement extremes
        run({2'b00, 1'b0, 4'd8, 3'b010, 22'h1fffff}, 32'h0000_1000, 4'd0, 0, "R4");
        run({2'b00, 1'b1, 4'd8, 3'b010, 22'h200000}, 32'h0100_0000, 4'd0, 0, "R4");
        run({2'b00, 1'b0, 4'd8, 3'b010, 22'h3fffff}, 32'h0000_0000, 4'd0, 0, "R4");

        // R3: calls, including wrap past the top of the address space
        for (int k = 0; k < 40; k++) begin
            run({2'b01, 30'(k * 32'h0123_4567 + 32'h3)}, 32'hfff0_0000 + 32'(k * 4),
                4'(k), 32'h5555_0000, "R3");
        end
        run({2'b01, 30'h3fff_ffff}, 32'h0000_0008, 4'd0, 0, "R3");

        // R7 R8: jump-and-link to every destination, including r0
        for (int r = 0; r < 32; r++) begin
            run({2'b10, 5'(r), 6'b111000, 5'd3, 1'b0, 13'(r * 97)}, 32'h0000_2000 + 32'(r * 4),
                4'hf, 32'h0800_0000 + 32'(r * 16), (r == 0) ? "R8" : "R7");
        end

        // R2: back-to-back stream mixing kinds
        for (int k = 0; k < 24; k++) begin
            logic [31:0] w;
            case (k % 4)
                0: w = {2'b01, 30'(k * 1111)};
                1: w = {2'b10, 5'(k), 6'b111000, 19'(k * 33)};
                2: w = {2'b00, 1'b0, 4'(k % 16), 3'b010, 22'(k * 4321)};
                default: w = {2'b11, 30'(k * 77777)};
            endcase
            run(w, 32'h0003_0000 + 32'(k * 8), 4'(k), 32'h0900_0000 + 32'(k), "R2");
        end

        // R9 R11 R10: set-high and other non-transfer formats
        for (int k = 0; k < 48; k++) begin
            logic [31:0] w;
            w = 32'(k) * 32'h9e37_79b9 + 32'h1357;
            case (k % 4)
                0: w = {2'b00, w[29:25], 3'b100, w[21:0]};
                1: w = {2'b11, w[29:0]};
                2: begin w[31:30] = 2'b10; if (w[24:19] == 6'b111000) w[19] = 1'b1; end
                default: begin
                    w[31:30] = 2'b00;
                    if (w[24:22] == 3'b010 || w[24:22] == 3'b100) w[24:22] = 3'b110;
                end
            endcase
            run(w, 32'h0000_4000 + 32'(k * 4), 4'(k), 32'hffff_fff0,
                (k % 4 == 0) ? "R11_R9" : "R9_R10");
        end
        run({2'b00, 5'd1, 3'b100, 22'h3fffff}, 32'hffff_fffc, 4'd0, 0, "R11");
        run({2'b11, 17'd0, 13'h1000}, 32'h0, 4'd0, 0, "R10");
        run({2'b11, 17'd0, 13'h0fff}, 32'h0, 4'd0, 0, "R10");

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule